// File: doc/BRIEF.md
# Real-Mode Data Operand Address Generator

This block forms the memory address of a data operand in a segmented real-mode machine. A caller presents the current contents of the two base registers (BX, BP), the two index registers (SI, DI), the data and stack segment values, an addressing form, a register selector and a displacement with its width. It then pulses `start_i`. One clock later the block presents the 16-bit effective offset, the 20-bit physical address and a flag that tells which segment was used. A one-cycle strobe marks the result as good, or as a fault when the form code is not a legal one.

The effective offset is the sum of whichever of base register, index register and displacement the form calls for. The sum wraps at 16 bits. A form whose base is BP addresses the stack segment, and every other form addresses the data segment. The physical address is the chosen segment shifted left by four bits plus the offset, and it wraps at 20 bits.

The control is a three-state machine, clocked by `clk`:
- `ST_IDLE`: no result is being presented.
- `ST_DONE`: a legal request was captured and `valid_o` is high.
- `ST_FAULT`: an illegal form was captured and `err_o` is high.

The transitions are:
- `start_i` with a legal form moves any state to `ST_DONE`.
- `start_i` with an illegal form moves any state to `ST_FAULT`.
- No `start_i` moves any state to `ST_IDLE`.

Top module: `ea_gen_top`

## Requirements
- R1: Form code 0 (direct) gives an offset equal to the displacement alone. The register selector and every register input have no effect.
- R2: Form code 1 (one register) gives an offset equal to one register, chosen by selector 0=BX, 1=BP, 2=SI, 3=DI. The displacement is ignored.
- R3: Form code 2 (base plus index) gives an offset of base plus index. Selector bit 1 picks the base (0=BX, 1=BP) and selector bit 0 picks the index (0=SI, 1=DI). The displacement is ignored.
- R4: Form code 3 (register plus displacement) gives an offset of the register chosen as in R2 plus the displacement.
- R5: Form code 4 (base plus index plus displacement) gives an offset of the base and index chosen as in R3 plus the displacement.
- R6: With `disp_wide_i`=0, bits 7:0 of the displacement are sign-extended to 16 bits and bits 15:8 are ignored. With `disp_wide_i`=1, all 16 bits are used as given.
- R7: The offset sum wraps modulo 2^16 before the segment is added.
- R8: `phys_o` equals the chosen segment times 16 plus the offset, modulo 2^20.
- R9: Forms 1 to 4 whose base is BP select `ss_i` and drive `stack_seg_o`=1. For forms 1 and 3 this means selector 1; for forms 2 and 4 it means selector bit 1 set. Every other case selects `ds_i` and drives `stack_seg_o`=0.
- R10: Form codes 5 to 7 raise `err_o` for one cycle with `valid_o` low. `offset_o`, `phys_o` and `stack_seg_o` then keep their previous values.
- R11: `valid_o` or `err_o` rises in exactly the cycle after a cycle with `start_i` high, and both are low otherwise. Results change only on a start, and a start held for back-to-back cycles gives a fresh result for each.
- R12: After reset, `valid_o`, `err_o` and `stack_seg_o` are low and `offset_o` and `phys_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request pulse; inputs sampled on this edge |
| form_i | input | 3 | Addressing form code (0..4 legal) |
| reg_sel_i | input | 2 | Register selector, meaning depends on form |
| bx_i | input | 16 | BX contents |
| bp_i | input | 16 | BP contents |
| si_i | input | 16 | SI contents |
| di_i | input | 16 | DI contents |
| ds_i | input | 16 | Data segment value |
| ss_i | input | 16 | Stack segment value |
| disp_i | input | 16 | Displacement |
| disp_wide_i | input | 1 | 1 = 16-bit displacement, 0 = 8-bit sign-extended |
| offset_o | output | 16 | Effective offset |
| phys_o | output | 20 | Physical address |
| stack_seg_o | output | 1 | 1 when the stack segment was used |
| valid_o | output | 1 | One-cycle strobe for a legal result |
| err_o | output | 1 | One-cycle strobe for an illegal form |

## Verification
The assertions watch the following on every cycle:
- the strobes follow a start by exactly one cycle and are never both high;
- outputs hold steady with no start, and a fault leaves the offset untouched;
- a direct form never reports the stack segment.

The arithmetic itself can only be shown by the bench's scenarios. These cover each form and selector, sign extension against wide displacements, 16-bit offset wrap, 20-bit physical wrap, the selectors that pick BP, and back-to-back starts.

// File: rtl/ea_gen_pkg.sv
package ea_gen_pkg;

    typedef enum logic [2:0] {
        FORM_DIRECT      = 3'd0,
        FORM_ONE_REG     = 3'd1,
        FORM_PAIR        = 3'd2,
        FORM_ONE_REG_DSP = 3'd3,
        FORM_PAIR_DSP    = 3'd4
    } ea_form_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DONE  = 2'd1,
        ST_FAULT = 2'd2
    } ea_state_e;

    localparam logic [1:0] SEL_BX = 2'd0;
    localparam logic [1:0] SEL_BP = 2'd1;
    localparam logic [1:0] SEL_SI = 2'd2;
    localparam logic [1:0] SEL_DI = 2'd3;

endpackage

// File: rtl/ea_operand_sel.sv
module ea_operand_sel
    import ea_gen_pkg::*;
#(
    parameter int OFS_W   = 16,
    parameter int SHORT_W = 8
) (
    input  logic [2:0]       form_i,
    input  logic [1:0]       sel_i,
    input  logic [OFS_W-1:0] bx_i,
    input  logic [OFS_W-1:0] bp_i,
    input  logic [OFS_W-1:0] si_i,
    input  logic [OFS_W-1:0] di_i,
    input  logic [OFS_W-1:0] disp_i,
    input  logic             disp_wide_i,
    output logic [OFS_W-1:0] term_a_o,
    output logic [OFS_W-1:0] term_b_o,
    output logic [OFS_W-1:0] term_c_o,
    output logic             use_stack_o,
    output logic             legal_o
);

    localparam int EXT_W = OFS_W - SHORT_W;

    logic [OFS_W-1:0] disp_norm;
    logic [OFS_W-1:0] single_reg;
    logic [OFS_W-1:0] base_reg;
    logic [OFS_W-1:0] index_reg;

    // Short displacements are sign-extended; wide ones pass through
    generate
        if (EXT_W > 0) begin : g_ext
            assign disp_norm = disp_wide_i ? disp_i
                             : {{EXT_W{disp_i[SHORT_W-1]}}, disp_i[SHORT_W-1:0]};
        end else begin : g_noext
            assign disp_norm = disp_i;
        end
    endgenerate

    always_comb begin
        unique case (sel_i)
            SEL_BX:  single_reg = bx_i;
            SEL_BP:  single_reg = bp_i;
            SEL_SI:  single_reg = si_i;
            default: single_reg = di_i;
        endcase
    end

    assign base_reg  = sel_i[1] ? bp_i : bx_i;
    assign index_reg = sel_i[0] ? di_i : si_i;

    always_comb begin
        term_a_o    = '0;
        term_b_o    = '0;
        term_c_o    = '0;
        use_stack_o = 1'b0;
        legal_o     = 1'b1;
        case (form_i)
            FORM_DIRECT: begin
                term_c_o = disp_norm;
            end
            FORM_ONE_REG: begin
                term_a_o    = single_reg;
                use_stack_o = (sel_i == SEL_BP);
            end
            FORM_PAIR: begin
                term_a_o    = base_reg;
                term_b_o    = index_reg;
                use_stack_o = sel_i[1];
            end
            FORM_ONE_REG_DSP: begin
                term_a_o    = single_reg;
                term_c_o    = disp_norm;
                use_stack_o = (sel_i == SEL_BP);
            end
            FORM_PAIR_DSP: begin
                term_a_o    = base_reg;
                term_b_o    = index_reg;
                term_c_o    = disp_norm;
                use_stack_o = sel_i[1];
            end
            default: begin
                legal_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/ea_adder.sv
module ea_adder #(
    parameter int OFS_W     = 16,
    parameter int SEG_SHIFT = 4
) (
    input  logic [OFS_W-1:0]           term_a_i,
    input  logic [OFS_W-1:0]           term_b_i,
    input  logic [OFS_W-1:0]           term_c_i,
    input  logic [OFS_W-1:0]           seg_i,
    output logic [OFS_W-1:0]           offset_o,
    output logic [OFS_W+SEG_SHIFT-1:0] phys_o
);

    localparam int PHYS_W = OFS_W + SEG_SHIFT;

    logic [PHYS_W-1:0] seg_scaled;
    logic [PHYS_W-1:0] ofs_wide;

    // Both sums drop their carry: 16-bit wrap for the offset, 20-bit for the address
    assign offset_o   = term_a_i + term_b_i + term_c_i;
    assign seg_scaled = {seg_i, {SEG_SHIFT{1'b0}}};
    assign ofs_wide   = {{SEG_SHIFT{1'b0}}, offset_o};
    assign phys_o     = seg_scaled + ofs_wide;

endmodule

// File: rtl/ea_gen_top.sv
module ea_gen_top
    import ea_gen_pkg::*;
#(
    parameter int OFS_W     = 16,
    parameter int SEG_SHIFT = 4,
    parameter int SHORT_W   = 8,
    localparam int PHYS_W   = OFS_W + SEG_SHIFT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [2:0]        form_i,
    input  logic [1:0]        reg_sel_i,
    input  logic [OFS_W-1:0]  bx_i,
    input  logic [OFS_W-1:0]  bp_i,
    input  logic [OFS_W-1:0]  si_i,
    input  logic [OFS_W-1:0]  di_i,
    input  logic [OFS_W-1:0]  ds_i,
    input  logic [OFS_W-1:0]  ss_i,
    input  logic [OFS_W-1:0]  disp_i,
    input  logic              disp_wide_i,
    output logic [OFS_W-1:0]  offset_o,
    output logic [PHYS_W-1:0] phys_o,
    output logic              stack_seg_o,
    output logic              valid_o,
    output logic              err_o
);

    logic [OFS_W-1:0]  t_a, t_b, t_c;
    logic              use_stack, legal;
    logic [OFS_W-1:0]  seg_pick;
    logic [OFS_W-1:0]  ofs_next;
    logic [PHYS_W-1:0] phys_next;
    ea_state_e         state_q, state_d;

    ea_operand_sel #(.OFS_W(OFS_W), .SHORT_W(SHORT_W)) u_sel (
        .form_i      (form_i),
        .sel_i       (reg_sel_i),
        .bx_i        (bx_i),
        .bp_i        (bp_i),
        .si_i        (si_i),
        .di_i        (di_i),
        .disp_i      (disp_i),
        .disp_wide_i (disp_wide_i),
        .term_a_o    (t_a),
        .term_b_o    (t_b),
        .term_c_o    (t_c),
        .use_stack_o (use_stack),
        .legal_o     (legal)
    );

    assign seg_pick = use_stack ? ss_i : ds_i;

    ea_adder #(.OFS_W(OFS_W), .SEG_SHIFT(SEG_SHIFT)) u_add (
        .term_a_i (t_a),
        .term_b_i (t_b),
        .term_c_i (t_c),
        .seg_i    (seg_pick),
        .offset_o (ofs_next),
        .phys_o   (phys_next)
    );

    // Next-state logic
    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE, ST_DONE, ST_FAULT: begin
                if (start_i) state_d = legal ? ST_DONE : ST_FAULT;
                else         state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Output registers: results load only on a legal start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            offset_o    <= '0;
            phys_o      <= '0;
            stack_seg_o <= 1'b0;
        end else if (start_i && legal) begin
            offset_o    <= ofs_next;
            phys_o      <= phys_next;
            stack_seg_o <= use_stack;
        end
    end

    assign valid_o = (state_q == ST_DONE);
    assign err_o   = (state_q == ST_FAULT);

    AST_START_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (valid_o ^ err_o)); // R11
    AST_NO_UNSOLICITED: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o || err_o) |-> $past(start_i)); // R11
    AST_QUIET_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> ($stable(offset_o) && $stable(phys_o))); // R11
    AST_STROBES_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(valid_o && err_o)); // R10
    AST_FAULT_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> ($stable(offset_o) && $stable(phys_o))); // R10
    AST_DIRECT_DATA_SEG: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && form_i == 3'd0) |=> !stack_seg_o); // R9

endmodule

// File: tb/ea_gen_top_tb_top.sv
module ea_gen_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [2:0]  form_i = '0;
    logic [1:0]  reg_sel_i = '0;
    logic [15:0] bx_i = '0, bp_i = '0, si_i = '0, di_i = '0;
    logic [15:0] ds_i = '0, ss_i = '0, disp_i = '0;
    logic        disp_wide_i = 1'b0;
    logic [15:0] offset_o;
    logic [19:0] phys_o;
    logic        stack_seg_o, valid_o, err_o;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    logic [15:0] m_ofs = '0;
    logic [19:0] m_phys = '0;
    logic        m_stk = 1'b0;

    always #2 clk = ~clk;

    ea_gen_top dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .form_i(form_i),
        .reg_sel_i(reg_sel_i), .bx_i(bx_i), .bp_i(bp_i), .si_i(si_i), .di_i(di_i),
        .ds_i(ds_i), .ss_i(ss_i), .disp_i(disp_i), .disp_wide_i(disp_wide_i),
        .offset_o(offset_o), .phys_o(phys_o), .stack_seg_o(stack_seg_o),
        .valid_o(valid_o), .err_o(err_o)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] pick1(logic [1:0] s);
        case (s)
            2'd0: return bx_i;
            2'd1: return bp_i;
            2'd2: return si_i;
            default: return di_i;
        endcase
    endfunction

    // Expected model from the requirements
    function automatic void model(output logic [15:0] ofs, output logic stk,
                                  output logic legal);
        logic [15:0] d;
        logic [15:0] b;
        logic [15:0] x;
        d = disp_wide_i ? disp_i : {{8{disp_i[7]}}, disp_i[7:0]};
        b = reg_sel_i[1] ? bp_i : bx_i;
        x = reg_sel_i[0] ? di_i : si_i;
        legal = 1'b1;
        stk = 1'b0;
        ofs = '0;
        case (form_i)
            3'd0: ofs = d;
            3'd1: begin ofs = pick1(reg_sel_i);     stk = (reg_sel_i == 2'd1); end
            3'd2: begin ofs = b + x;                stk = reg_sel_i[1]; end
            3'd3: begin ofs = pick1(reg_sel_i) + d; stk = (reg_sel_i == 2'd1); end
            3'd4: begin ofs = b + x + d;            stk = reg_sel_i[1]; end
            default: legal = 1'b0;
        endcase
    endfunction

    function automatic string tag_of(logic [2:0] f);
        case (f)
            3'd0: return "R1";
            3'd1: return "R2";
            3'd2: return "R3";
            3'd3: return "R4";
            3'd4: return "R5";
            default: return "R10";
        endcase
    endfunction

    // Compute expected from current inputs; update the bench model
    task automatic expect_now(output logic legal);
        logic [15:0] o;
        logic        s;
        logic [19:0] p;
        model(o, s, legal);
        p = {(s ? ss_i : ds_i), 4'h0} + {4'h0, o};
        if (legal) begin
            m_ofs = o;
            m_phys = p;
            m_stk = s;
        end
    endtask

    task automatic check_result(string tag, logic legal);
        chk({tag, " valid/R11"}, {31'd0, valid_o}, {31'd0, legal});
        chk({tag, " err/R10"}, {31'd0, err_o}, {31'd0, !legal});
        chk({tag, " offset"}, {16'd0, offset_o}, {16'd0, m_ofs});
        chk({tag, " phys/R8"}, {12'd0, phys_o}, {12'd0, m_phys});
        chk({tag, " stack/R9"}, {31'd0, stack_seg_o}, {31'd0, m_stk});
    endtask

    task automatic apply(logic [2:0] f, logic [1:0] s, logic [15:0] bx, logic [15:0] bp,
                         logic [15:0] si, logic [15:0] di, logic [15:0] ds,
                         logic [15:0] ss, logic [15:0] d, logic w, string tag);
        logic legal;
        @(negedge clk);
        form_i = f; reg_sel_i = s; bx_i = bx; bp_i = bp; si_i = si; di_i = di;
        ds_i = ds; ss_i = ss; disp_i = d; disp_wide_i = w; start_i = 1'b1;
        expect_now(legal);
        @(negedge clk);
        start_i = 1'b0;
        check_result(tag, legal);
        @(negedge clk);
        chk({tag, " strobe drop R11"}, {30'd0, valid_o, err_o}, 32'd0);
        chk({tag, " hold R11"}, {16'd0, offset_o}, {16'd0, m_ofs});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R12 reset state
        chk("R12 valid", {31'd0, valid_o}, 32'd0);
        chk("R12 err", {31'd0, err_o}, 32'd0);
        chk("R12 offset", {16'd0, offset_o}, 32'd0);
        chk("R12 phys", {12'd0, phys_o}, 32'd0);
        chk("R12 stack", {31'd0, stack_seg_o}, 32'd0);
        rst_n = 1'b1;

        // R1 direct, registers ignored
        apply(3'd0, 2'd1, 16'hAAAA, 16'hBBBB, 16'hCCCC, 16'hDDDD, 16'h1000, 16'h2000, 16'h1234, 1'b1, "R1");
        // R6 short disp sign-extends, upper byte ignored
        apply(3'd0, 2'd0, 0, 0, 0, 0, 16'h0100, 0, 16'h5580, 1'b0, "R6 neg");
        apply(3'd0, 2'd0, 0, 0, 0, 0, 16'h0100, 0, 16'hEE7F, 1'b0, "R6 pos");
        // R2 each register
        for (int k = 0; k < 4; k++)
            apply(3'd1, k[1:0], 16'h0011, 16'h0022, 16'h0033, 16'h0044, 16'h0300, 16'h0400, 16'hFFFF, 1'b1, "R2");
        // R3, R9 all pairs
        for (int k = 0; k < 4; k++)
            apply(3'd2, k[1:0], 16'h0100, 16'h0200, 16'h0010, 16'h0020, 16'h0500, 16'h0600, 16'h7777, 1'b1, "R3");
        // R4 with short and wide disp
        apply(3'd3, 2'd1, 0, 16'h1000, 0, 0, 16'h0700, 16'h0800, 16'h00FC, 1'b0, "R4");
        apply(3'd3, 2'd3, 0, 0, 0, 16'h1000, 16'h0700, 16'h0800, 16'h0204, 1'b1, "R4");
        // R5
        apply(3'd4, 2'd2, 16'h1, 16'h1000, 16'h2, 16'h20, 16'h0900, 16'h0A00, 16'h0004, 1'b0, "R5");
        // R7 offset wrap
        apply(3'd2, 2'd0, 16'hFFFF, 0, 16'h0002, 0, 16'h0000, 0, 0, 1'b1, "R7");
        apply(3'd4, 2'd3, 0, 16'hFFF0, 0, 16'h0008, 0, 16'h0001, 16'h0010, 1'b1, "R7");
        // R8 physical wrap
        apply(3'd1, 2'd0, 16'h0020, 0, 0, 0, 16'hFFFF, 0, 0, 1'b1, "R8");
        // R10 illegal forms keep previous outputs
        apply(3'd5, 2'd1, 16'h1, 16'h2, 16'h3, 16'h4, 16'h1, 16'h2, 16'h3, 1'b1, "R10");
        apply(3'd7, 2'd3, 16'h9, 16'h9, 16'h9, 16'h9, 16'h9, 16'h9, 16'h9, 1'b1, "R10");

        // R11 back-to-back starts
        begin
            logic lg;
            @(negedge clk);
            form_i = 3'd1; reg_sel_i = 2'd0; bx_i = 16'h0AB0; ds_i = 16'h0001; start_i = 1'b1;
            expect_now(lg);
            @(negedge clk);
            check_result("R11 first", lg);
            form_i = 3'd1; reg_sel_i = 2'd1; bp_i = 16'h0CD0; ss_i = 16'h0002;
            expect_now(lg);
            @(negedge clk);
            start_i = 1'b0;
            check_result("R11 second", lg);
        end

        void'($urandom(32'h5EED));
        for (int v = 0; v < 400; v++) begin
            logic [2:0] f;
            f = 3'($urandom % 8);
            apply(f, 2'($urandom), 16'($urandom), 16'($urandom), 16'($urandom),
                  16'($urandom), 16'($urandom), 16'($urandom), 16'($urandom),
                  1'($urandom), tag_of(f));
        end

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog R11 actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule